// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a simple single-word host port and an asynchronous DRAM whose address pins are shared between row and column. For each accepted host request it runs one full memory cycle: it drives the row half of the address and pulls the row strobe low, then drives the column half and pulls the column strobe low, then returns both strobes high and holds them there for the precharge time. All analog timing limits (row-active minimum, row and column precharge, row-to-column delay, read access delay) are parameters counted in clock cycles. A single down-counter measures each phase.

After reset the controller waits a power-up pause and then runs a set of dummy row-only cycles. Only after these does it accept host traffic. From then on an interval counter raises a refresh request at the rate that the refresh variant needs. The controller serves that request with a column-before-row refresh cycle. A pending refresh wins over a waiting host request, but a host cycle that has already started always finishes first. A parameter selects the 2K-refresh variant (11 address pins, 2048 rows per 32 ms) or the 4K-refresh variant (12 pins, 4096 rows per 64 ms). The default refresh interval is computed from that choice and the clock frequency.

Top module: `adram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, all four strobes are high, `dr_dq_oe` is low, and `host_ready` and `host_rvalid` are low.
- R2: `host_ready` stays low until the power-up pause of `PWRUP_CYC` cycles has passed and at least `N_INIT` (default 8) row-only cycles have run, with the column strobe high the whole time.
- R3: The row address is `host_addr[2*AW-1:AW]` and is on `dr_ma` when `dr_ras_n` falls. The column address is `host_addr[AW-1:0]` and is on `dr_ma` when `dr_cas_n` falls.
- R4: In a write, `dr_we_n` is low only while `dr_cas_n` is low. `dr_dq_oe` is high and `dr_dq_out` carries `host_wdata` from before the column strobe falls, so a later read of the same address returns that data.
- R5: In a read, `dr_we_n` stays high and `dr_oe_n` is low while the column strobe is low. `host_rdata` is taken from `dr_dq_in` at least `T_ACC` cycles after the column strobe falls. `host_rvalid` is a single-cycle pulse.
- R6: A refresh drops `dr_cas_n` before `dr_ras_n`. `dr_oe_n` stays high and `dr_dq_oe` stays low throughout. Refreshes repeat every `REF_INTERVAL` cycles when the block is idle.
- R7: Every row-strobe low period lasts at least `T_RAS` cycles.
- R8: The row strobe stays high for at least `T_RP` cycles and the column strobe for at least `T_CP` cycles before either falls again.
- R9: In an access, the column strobe falls no earlier than `T_RCD` cycles after the row strobe.
- R10: A request is accepted only when `req` and `ready` are both high. `ready` drops on the next cycle and stays low until precharge ends. `ready` is never high while a strobe is low. A request made while `ready` is low starts no memory cycle and changes no stored data.
- R11: A pending refresh is served before a waiting host request, and an access already in progress completes first. Under back-to-back host traffic, the gap between refreshes never exceeds `REF_INTERVAL` plus one access and one refresh lead-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2*AW | Word address, row in upper half, column in lower half |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data, valid with host_rvalid |
| host_ready | output | 1 | Controller idle and able to accept a request |
| host_rvalid | output | 1 | One-cycle read-data pulse |
| dr_ras_n | output | 1 | Row strobe, active low |
| dr_cas_n | output | 1 | Column strobe, active low |
| dr_we_n | output | 1 | Write enable, active low |
| dr_oe_n | output | 1 | Output enable, active low |
| dr_ma | output | AW | Multiplexed row/column address |
| dr_dq_in | input | DW | Data from the DRAM |
| dr_dq_out | output | DW | Data to the DRAM |
| dr_dq_oe | output | 1 | Drive enable for dr_dq_out |

## Verification
The bench builds the 2K variant (22-bit host address, 4-bit data) with short timings: row active 4, row precharge 3, column precharge 2, row-to-column 2, access 3, power-up pause 20, and a refresh interval of 80 cycles in place of the derived value. With these values the whole start-up sequence, many refreshes and refresh collisions with back-to-back host traffic fit into a few thousand cycles. Row and column lengths of 2 and 3 cycles differ, so a swapped or mis-counted phase shows up. The extreme addresses exercise both address halves fully.

// File: rtl/adram_pkg.sv
package adram_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP   = 4'd0,
        ST_INIT_RAS,
        ST_INIT_PRE,
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PRE,
        ST_REF_CAS,
        ST_REF_RAS
    } ctl_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int addr_bits(input bit big_refresh);
        return big_refresh ? 12 : 11;
    endfunction

    // cycles between refresh requests: period / rows, in clocks
    function automatic int ref_interval(input bit big_refresh, input int clk_mhz);
        int rows;
        int period_us;
        rows      = big_refresh ? 4096 : 2048;
        period_us = big_refresh ? 64000 : 32000;
        return (period_us * clk_mhz) / rows;
    endfunction

endpackage

// File: rtl/adram_delay.sv
module adram_delay #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= len - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/adram_refresh_sched.sv
module adram_refresh_sched #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CW'(INTERVAL - 1);
            pend_q <= 1'b0;
        end else if (enable) begin
            if (cnt_q == '0) begin
                cnt_q  <= CW'(INTERVAL - 1);
                pend_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - CW'(1);
                if (ack) pend_q <= 1'b0;
            end
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/adram_ctrl.sv
module adram_ctrl
    import adram_pkg::*;
#(
    parameter bit BIG_REFRESH  = 1'b0,
    parameter int DW           = 4,
    parameter int CLK_MHZ      = 50,
    parameter int PWRUP_CYC    = 200 * CLK_MHZ,
    parameter int N_INIT       = 8,
    parameter int T_RAS        = 3,
    parameter int T_RP         = 2,
    parameter int T_CP         = 1,
    parameter int T_RCD        = 1,
    parameter int T_ACC        = 3,
    parameter int T_CSR        = 1,
    parameter int REF_INTERVAL = ref_interval(BIG_REFRESH, CLK_MHZ),
    localparam int AW          = addr_bits(BIG_REFRESH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            host_req,
    input  logic            host_we,
    input  logic [2*AW-1:0] host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic            host_ready,
    output logic            host_rvalid,
    output logic            dr_ras_n,
    output logic            dr_cas_n,
    output logic            dr_we_n,
    output logic            dr_oe_n,
    output logic [AW-1:0]   dr_ma,
    input  logic [DW-1:0]   dr_dq_in,
    output logic [DW-1:0]   dr_dq_out,
    output logic            dr_dq_oe
);
    // derived phase lengths
    localparam int COL_LEN = max2(max2(T_ACC, T_RAS - T_RCD), 1);
    localparam int PRE_LEN = max2(max2(T_RP, T_CP), 1);
    localparam int LONGEST = max2(max2(max2(PWRUP_CYC, T_RAS), max2(T_RCD, T_CSR)),
                                  max2(COL_LEN, PRE_LEN));
    localparam int TW      = $clog2(LONGEST + 1);
    localparam int IW      = $clog2(N_INIT + 1);

    typedef struct packed {
        logic          we;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
        logic [DW-1:0] wd;
    } host_req_t;

    ctl_state_e st_q, st_d;
    host_req_t  req_q;
    logic [IW-1:0] init_cnt_q;
    logic       init_done_q;
    logic       tmr_load, tmr_done;
    logic [TW-1:0] tmr_len;
    logic       ref_pend, ref_ack;
    logic       accept, rd_cap, init_step;
    strobe_t    pins;
    logic [DW-1:0] rdata_q;
    logic       rvalid_q;

    adram_delay #(.W(TW), .RST_VAL(PWRUP_CYC - 1)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .len  (tmr_len),
        .done (tmr_done)
    );

    adram_refresh_sched #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk    (clk),
        .rst    (rst),
        .enable (init_done_q),
        .ack    (ref_ack),
        .pend   (ref_pend)
    );

    // next-state and phase-timer loading
    always_comb begin
        st_d      = st_q;
        tmr_load  = 1'b0;
        tmr_len   = '0;
        ref_ack   = 1'b0;
        accept    = 1'b0;
        rd_cap    = 1'b0;
        init_step = 1'b0;
        unique case (st_q)
            ST_PWRUP: if (tmr_done) begin
                st_d = ST_INIT_RAS; tmr_load = 1'b1; tmr_len = TW'(T_RAS);
            end
            ST_INIT_RAS: if (tmr_done) begin
                st_d = ST_INIT_PRE; tmr_load = 1'b1; tmr_len = TW'(T_RP);
            end
            ST_INIT_PRE: if (tmr_done) begin
                init_step = 1'b1;
                if (init_cnt_q == IW'(N_INIT - 1)) begin
                    st_d = ST_IDLE;
                end else begin
                    st_d = ST_INIT_RAS; tmr_load = 1'b1; tmr_len = TW'(T_RAS);
                end
            end
            ST_IDLE: begin
                if (ref_pend) begin
                    st_d = ST_REF_CAS; tmr_load = 1'b1; tmr_len = TW'(T_CSR);
                    ref_ack = 1'b1;
                end else if (host_req) begin
                    st_d = ST_ROW; tmr_load = 1'b1; tmr_len = TW'(T_RCD);
                    accept = 1'b1;
                end
            end
            ST_ROW: if (tmr_done) begin
                st_d = ST_COL; tmr_load = 1'b1; tmr_len = TW'(COL_LEN);
            end
            ST_COL: if (tmr_done) begin
                st_d = ST_PRE; tmr_load = 1'b1; tmr_len = TW'(PRE_LEN);
                rd_cap = !req_q.we;
            end
            ST_PRE: if (tmr_done) begin
                st_d = ST_IDLE;
            end
            ST_REF_CAS: if (tmr_done) begin
                st_d = ST_REF_RAS; tmr_load = 1'b1; tmr_len = TW'(T_RAS);
            end
            ST_REF_RAS: if (tmr_done) begin
                st_d = ST_PRE; tmr_load = 1'b1; tmr_len = TW'(PRE_LEN);
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_PWRUP;
            req_q       <= '0;
            init_cnt_q  <= '0;
            init_done_q <= 1'b0;
            rdata_q     <= '0;
            rvalid_q    <= 1'b0;
        end else begin
            st_q     <= st_d;
            rvalid_q <= rd_cap;
            if (accept) begin
                req_q.we  <= host_we;
                req_q.row <= host_addr[2*AW-1:AW];
                req_q.col <= host_addr[AW-1:0];
                req_q.wd  <= host_wdata;
            end
            if (init_step) init_cnt_q <= init_cnt_q + IW'(1);
            if (init_step && st_d == ST_IDLE) init_done_q <= 1'b1;
            if (rd_cap) rdata_q <= dr_dq_in;
        end
    end

    // strobe decode
    always_comb begin
        pins = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        unique case (st_q)
            ST_INIT_RAS, ST_ROW: pins.ras_n = 1'b0;
            ST_COL: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
                pins.we_n  = !req_q.we;
                pins.oe_n  = req_q.we;
            end
            ST_REF_CAS: pins.cas_n = 1'b0;
            ST_REF_RAS: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_ROW:      dr_ma = req_q.row;
            ST_COL:      dr_ma = req_q.col;
            ST_INIT_RAS: dr_ma = AW'(init_cnt_q);
            default:     dr_ma = '0;
        endcase
    end

    assign dr_ras_n    = pins.ras_n;
    assign dr_cas_n    = pins.cas_n;
    assign dr_we_n     = pins.we_n;
    assign dr_oe_n     = pins.oe_n;
    assign dr_dq_out   = req_q.wd;
    assign dr_dq_oe    = req_q.we && (st_q == ST_ROW || st_q == ST_COL);
    assign host_ready  = (st_q == ST_IDLE) && !ref_pend;
    assign host_rdata  = rdata_q;
    assign host_rvalid = rvalid_q;
endmodule

// File: rtl/adram_ctrl_chk.sv
module adram_ctrl_chk #(
    parameter int T_RAS = 3,
    parameter int T_RP  = 2,
    parameter int T_CP  = 1,
    parameter int T_RCD = 1
) (
    input logic clk,
    input logic rst,
    input logic host_req,
    input logic host_ready,
    input logic host_rvalid,
    input logic dr_ras_n,
    input logic dr_cas_n,
    input logic dr_we_n,
    input logic dr_oe_n,
    input logic dr_dq_oe
);
    localparam int TMAX = (T_RAS > T_RP ? T_RAS : T_RP) + T_CP + T_RCD;
    localparam int CW   = $clog2(TMAX + 2);
    localparam logic [CW-1:0] SAT = '1;

    logic [CW-1:0] ras_lo_c, ras_hi_c, cas_hi_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_lo_c <= '0;
            ras_hi_c <= SAT;
            cas_hi_c <= SAT;
        end else begin
            ras_lo_c <= dr_ras_n ? '0 : ((ras_lo_c == SAT) ? SAT : ras_lo_c + CW'(1));
            ras_hi_c <= !dr_ras_n ? '0 : ((ras_hi_c == SAT) ? SAT : ras_hi_c + CW'(1));
            cas_hi_c <= !dr_cas_n ? '0 : ((cas_hi_c == SAT) ? SAT : cas_hi_c + CW'(1));
        end
    end

    assert_ras_active_min_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dr_ras_n) |-> ras_lo_c >= CW'(T_RAS));

    assert_ras_precharge_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(dr_ras_n) |-> ras_hi_c >= CW'(T_RP));

    assert_cas_precharge_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(dr_cas_n) |-> cas_hi_c >= CW'(T_CP));

    assert_row_to_col_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(dr_cas_n) && !dr_ras_n) |-> ras_lo_c >= CW'(T_RCD));

    assert_refresh_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (!dr_cas_n && dr_ras_n) |-> (dr_oe_n && !dr_dq_oe));

    assert_refresh_order_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(dr_ras_n) && !dr_cas_n) |-> ($past(!dr_cas_n) && dr_oe_n && !dr_dq_oe));

    assert_write_drive_R4: assert property (@(posedge clk) disable iff (rst)
        !dr_we_n |-> (dr_dq_oe && !dr_cas_n));

    assert_ready_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ready) |=> !host_ready);

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (dr_ras_n && dr_cas_n));

    assert_rvalid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid);
endmodule

bind adram_ctrl adram_ctrl_chk #(
    .T_RAS (T_RAS),
    .T_RP  (T_RP),
    .T_CP  (T_CP),
    .T_RCD (T_RCD)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .dr_ras_n    (dr_ras_n),
    .dr_cas_n    (dr_cas_n),
    .dr_we_n     (dr_we_n),
    .dr_oe_n     (dr_oe_n),
    .dr_dq_oe    (dr_dq_oe)
);

// File: tb/sim_adram_ctrl.sv
module sim_adram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 11;
    localparam int DW    = 4;
    localparam int PWRUP = 20;
    localparam int NINIT = 8;
    localparam int TRAS  = 4;
    localparam int TRP   = 3;
    localparam int TCP   = 2;
    localparam int TRCD  = 2;
    localparam int TACC  = 3;
    localparam int TCSR  = 1;
    localparam int REFI  = 80;
    localparam int ACC_LEN = TRCD + 3 + 3;
    localparam int GAP_MAX = REFI + ACC_LEN + TCSR + 2;

    typedef struct packed {
        logic          we;
        logic [2*AW-1:0] addr;
        logic [DW-1:0] data;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 22'h000000, 4'h5},
        '{1'b1, 22'h3FFFFF, 4'hA},
        '{1'b1, 22'h3FF800, 4'h3},
        '{1'b1, 22'h0007FF, 4'hC},
        '{1'b1, 22'h12A4C3, 4'h9},
        '{1'b0, 22'h000000, 4'h5},
        '{1'b0, 22'h3FFFFF, 4'hA},
        '{1'b0, 22'h3FF800, 4'h3},
        '{1'b0, 22'h0007FF, 4'hC},
        '{1'b1, 22'h12A4C3, 4'h6},
        '{1'b0, 22'h12A4C3, 4'h6},
        '{1'b0, 22'h3FF800, 4'h3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 1'b0, host_we = 1'b0;
    logic [2*AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0, host_rdata;
    logic host_ready, host_rvalid;
    logic ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [AW-1:0] ma;
    logic [DW-1:0] dq_in, dq_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    adram_ctrl #(
        .BIG_REFRESH(1'b0), .DW(DW), .PWRUP_CYC(PWRUP), .N_INIT(NINIT),
        .T_RAS(TRAS), .T_RP(TRP), .T_CP(TCP), .T_RCD(TRCD), .T_ACC(TACC),
        .T_CSR(TCSR), .REF_INTERVAL(REFI)
    ) u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .host_rvalid(host_rvalid),
        .dr_ras_n(ras_n), .dr_cas_n(cas_n), .dr_we_n(we_n), .dr_oe_n(oe_n),
        .dr_ma(ma), .dr_dq_in(dq_in), .dr_dq_out(dq_out), .dr_dq_oe(dq_oe)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- DRAM model and timing monitor ----------------
    logic [DW-1:0] mem [int];
    logic [DW-1:0] rd_word = '0;
    logic [AW-1:0] m_row = '0;
    logic [2*AW-1:0] exp_addr = '0;
    bit   ready_seen = 0;
    int   cyc = 0;
    int   init_rows = 0, early_cas = 0, ref_cnt = 0, last_ref = -1, max_gap = 0;
    int   ras_lo = 0, ras_hi = 1000, cas_hi = 1000;
    int   v_ras = 0, v_rp = 0, v_cp = 0, v_rcd = 0, v_refq = 0, v_wr = 0, v_addr = 0;
    logic p_ras = 1'b1, p_cas = 1'b1;

    assign dq_in = (!oe_n && !cas_n) ? rd_word : '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (host_ready) ready_seen = 1;
            if (p_ras && !ras_n) begin
                if (ras_hi < TRP) v_rp++;
                if (!cas_n) begin
                    ref_cnt++;
                    if (!oe_n || dq_oe || p_cas) v_refq++;
                    if (last_ref >= 0 && cyc - last_ref > max_gap) max_gap = cyc - last_ref;
                    last_ref = cyc;
                end else begin
                    m_row = ma;
                    if (!ready_seen) init_rows++;
                end
            end
            if (!p_ras && ras_n && ras_lo < TRAS) v_ras++;
            if (p_cas && !cas_n) begin
                if (cas_hi < TCP) v_cp++;
                if (!ras_n) begin
                    int a;
                    if (ras_lo < TRCD) v_rcd++;
                    if (!ready_seen) early_cas++;
                    if ({m_row, ma} != exp_addr) v_addr++;
                    a = int'({m_row, ma});
                    if (!we_n) begin
                        if (!dq_oe) v_wr++;
                        mem[a] = dq_out;
                    end else begin
                        if (oe_n) v_wr++;
                        rd_word = mem.exists(a) ? mem[a] : '0;
                    end
                end
            end
            ras_lo = ras_n ? 0 : ras_lo + 1;
            ras_hi = ras_n ? ras_hi + 1 : 0;
            cas_hi = cas_n ? cas_hi + 1 : 0;
            p_ras = ras_n;
            p_cas = cas_n;
        end
    end

    // ---------------- host access ----------------
    task automatic host_op(input bit we, input logic [2*AW-1:0] addr,
                           input logic [DW-1:0] wd, input logic [DW-1:0] exp_rd,
                           input bit do_chk);
        int t;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        exp_addr   = addr;
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = addr;
        host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        if (do_chk) check(!host_ready, "R10 ready drop", host_ready, 0);
        if (!we) begin
            t = 0;
            while (!host_rvalid && t < 100) begin @(negedge clk); t++; end
            if (do_chk) begin
                check(host_rvalid, "R5 rvalid seen", host_rvalid, 1);
                check(host_rdata == exp_rd, "R5/R4 read data", host_rdata, exp_rd);
                @(negedge clk);
                check(!host_rvalid, "R5 rvalid pulse", host_rvalid, 0);
            end
        end
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int t_ready;
        int r0;
        repeat (4) @(negedge clk);
        check(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset",
              {ras_n, cas_n, we_n, oe_n}, 15);
        check(!dq_oe && !host_ready && !host_rvalid, "R1 outputs in reset",
              {dq_oe, host_ready, host_rvalid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ras_n && cas_n && !host_ready, "R1 after reset",
              {ras_n, cas_n, host_ready}, 6);

        // request during start-up must be ignored (R10)
        repeat (3) @(negedge clk);
        exp_addr = 22'h000155;
        host_req = 1'b1; host_we = 1'b1; host_addr = 22'h000155; host_wdata = 4'hF;
        @(negedge clk);
        host_req = 1'b0;

        t_ready = 5;
        while (!host_ready && t_ready < 2000) begin @(negedge clk); t_ready++; end
        check(t_ready >= PWRUP + NINIT * (TRAS + TRP), "R2 start-up length",
              t_ready, PWRUP + NINIT * (TRAS + TRP));
        check(init_rows >= NINIT, "R2 dummy row cycles", init_rows, NINIT);
        check(early_cas == 0, "R10 no access before ready", early_cas, 0);
        host_op(1'b0, 22'h000155, '0, 4'h0, 1'b1);

        // vector table
        for (int i = 0; i < NV; i++)
            host_op(VECS[i].we, VECS[i].addr, VECS[i].data, VECS[i].data, !VECS[i].we);
        check(v_addr == 0, "R3 row/column on pins", v_addr, 0);

        // idle refresh rate (R6)
        r0 = ref_cnt;
        repeat (4 * REFI) @(negedge clk);
        check(ref_cnt - r0 >= 3, "R6 idle refresh count", ref_cnt - r0, 4);
        check(max_gap <= REFI + 2, "R6 idle refresh period", max_gap, REFI);

        // back-to-back traffic against refresh (R11)
        max_gap = 0;
        for (int k = 0; k < 60; k++)
            host_op(1'b0, VECS[k % 5].addr, '0,
                    (k % 5 == 4) ? 4'h6 : VECS[k % 5].data, 1'b1);
        check(max_gap > 0 && max_gap <= GAP_MAX, "R11 refresh gap under load",
              max_gap, GAP_MAX);

        check(v_ras == 0, "R7 row active minimum", v_ras, 0);
        check(v_rp == 0, "R8 row precharge", v_rp, 0);
        check(v_cp == 0, "R8 column precharge", v_cp, 0);
        check(v_rcd == 0, "R9 row-to-column delay", v_rcd, 0);
        check(v_refq == 0, "R6 refresh order and quiet bus", v_refq, 0);
        check(v_wr == 0, "R4/R5 write/read enables at CAS", v_wr, 0);
        check(v_addr == 0, "R3 address halves", v_addr, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule